// File: doc/BRIEF.md
# Eight-Channel Block Transfer Engine

This block moves bytes between a 24-bit memory space and a 256-byte peripheral register page. Each of its channels holds a control byte, a peripheral register index, a 24-bit memory address and a 16-bit byte count. Software programs these through a byte-wide configuration port and can read each one back. A single write to a start register launches every channel whose bit is set. The engine then serves those channels one at a time, in ascending channel order. For each byte it issues one read and then one write on a single-beat bus master port. Each phase completes when the bus returns ready.

The control byte sets the copy direction, whether the memory address steps up, steps down or stays put, and a pattern mode. In mode 1 the peripheral side alternates between two adjacent registers. Once a transfer ends, the memory address register holds the address that follows the last byte moved, and the count register holds zero. Software can read both back.

Top module: `dma8_engine`

## Requirements
- R1: Per-channel registers sit at configuration address 0x4300 + 0x10*n, where bits [6:4] give the channel n and bits [3:0] give the offset. The offsets are: 0 control, 1 peripheral index, 2/3/4 memory address bits [7:0]/[15:8]/[23:16], 5/6 count bits [7:0]/[15:8]. Reading an offset returns the stored value. The control byte reads back with bit 5 forced to 0.
- R2: A write to any one byte of the memory address changes only that byte.
- R3: A write to address 0x420B starts each channel n whose data bit n is 1. The channels run strictly one after another, lowest number first, and unselected channels issue no bus cycles.
- R4: Control bit 7 sets the direction. With bit 7 = 0, each byte is read from the memory address and written to the peripheral address. With bit 7 = 1, it is read from the peripheral address and written to the memory address. The write data always equals the data returned by the read just before it.
- R5: The peripheral address is 0x002100 OR (index + k), where the sum is 9 bits wide. In mode 1 (control bits [2:0] = 1), k starts at 0 for each channel and toggles after every byte. In any other mode, k stays 0.
- R6: After each byte, the memory address stays the same if control bit 3 is 1. Otherwise it decrements by one if control bit 4 is 1 and increments by one if bit 4 is 0, modulo 2^24.
- R7: A count of N moves N bytes, and a count of 0 moves 65536 bytes. Afterwards the count reads 0 and the memory address reads its final stepped value.
- R8: busy rises on the clock edge that accepts a start write with a nonzero mask, and falls after the last selected channel's final write. Start writes made while busy have no effect.
- R9: While bus_req is high and bus_ready is low, bus_req, bus_we, bus_addr and bus_wdata hold their values.
- R10: After reset, busy and bus_req are low and every channel register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 16 | Configuration address for both write and read |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational read-back of the register at cfg_addr |
| bus_req | output | 1 | Bus phase request |
| bus_we | output | 1 | 1 = write phase, 0 = read phase |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled on the ready edge |
| bus_ready | input | 1 | Completes the current phase on this edge |
| busy | output | 1 | High while channels are pending or running |

## Verification
busy rises on the same edge that takes the start write, so the bench tests it at the next falling edge. The first read request follows one cycle later, after a channel-selection cycle. Each bus phase then completes on the rising edge where bus_ready is high, and the bench drives bus_ready at the falling edge and samples the request 1 ns later. That sampled value is exactly what the next rising edge will act on, and each completed phase is compared in order against a transaction list computed from the requirements. Register read-back is combinational and is sampled within the same half cycle as the address change.

// File: rtl/dma8_pkg.sv
package dma8_pkg;
   localparam int AW = 24;
   localparam int CW = 16;
   localparam int DW = 8;

   typedef struct packed {
      logic       to_mem;
      logic       indir;
      logic       dec;
      logic       fixed;
      logic [2:0] mode;
   } ch_ctrl_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PICK,
      ST_RD,
      ST_WR
   } seq_state_t;

   function automatic logic [7:0] ctrl_to_byte(input ch_ctrl_t c);
      return {c.to_mem, c.indir, 1'b0, c.dec, c.fixed, c.mode};
   endfunction

   function automatic ch_ctrl_t byte_to_ctrl(input logic [7:0] b);
      ch_ctrl_t c;
      c.to_mem = b[7];
      c.indir  = b[6];
      c.dec    = b[4];
      c.fixed  = b[3];
      c.mode   = b[2:0];
      return c;
   endfunction
endpackage

// File: rtl/dma8_regbank.sv
module dma8_regbank
   import dma8_pkg::*;
#(
   parameter int              NUM_CH  = 8,
   parameter int              CFG_AW  = 16,
   parameter logic [15:0]     CH_BASE = 16'h4300,
   parameter int              CHW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [DW-1:0]     cfg_wdata,
   output logic [DW-1:0]     cfg_rdata,
   input  logic [CHW-1:0]    act_ch,
   input  logic              step,
   output logic              act_to_mem,
   output logic [2:0]        act_mode,
   output logic [7:0]        act_bb,
   output logic [AW-1:0]     act_addr,
   output logic [CW-1:0]     act_cnt
);
   localparam int OFF_W = 4;

   ch_ctrl_t          ctrl_a [NUM_CH];
   logic [7:0]        bb_a   [NUM_CH];
   logic [AW-1:0]     addr_a [NUM_CH];
   logic [CW-1:0]     cnt_a  [NUM_CH];

   logic              blk_hit;
   logic [2:0]        sel_ch;
   logic [OFF_W-1:0]  off;

   assign blk_hit = (cfg_addr[CFG_AW-1:7] == CH_BASE[CFG_AW-1:7]);
   assign sel_ch  = cfg_addr[6:4];
   assign off     = cfg_addr[OFF_W-1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ch_ctrl_t      ctrl_r;
      logic [7:0]    bb_r;
      logic [AW-1:0] addr_r;
      logic [CW-1:0] cnt_r;
      logic          wsel;
      logic          mine;

      assign wsel = cfg_we && blk_hit && (sel_ch == 3'(c));
      assign mine = step && (act_ch == CHW'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_r <= '0;
            bb_r   <= '0;
            addr_r <= '0;
            cnt_r  <= '0;
         end else begin
            if (wsel && off == 4'd0) ctrl_r <= byte_to_ctrl(cfg_wdata);
            if (wsel && off == 4'd1) bb_r <= cfg_wdata;

            if (wsel && off == 4'd2)      addr_r[7:0]   <= cfg_wdata;
            else if (wsel && off == 4'd3) addr_r[15:8]  <= cfg_wdata;
            else if (wsel && off == 4'd4) addr_r[23:16] <= cfg_wdata;
            else if (mine && !ctrl_r.fixed)
               addr_r <= ctrl_r.dec ? addr_r - AW'(1) : addr_r + AW'(1);

            if (wsel && off == 4'd5)      cnt_r[7:0]  <= cfg_wdata;
            else if (wsel && off == 4'd6) cnt_r[15:8] <= cfg_wdata;
            else if (mine)                cnt_r <= cnt_r - CW'(1);
         end
      end

      assign ctrl_a[c] = ctrl_r;
      assign bb_a[c]   = bb_r;
      assign addr_a[c] = addr_r;
      assign cnt_a[c]  = cnt_r;
   end

   ch_ctrl_t act_ctrl;
   assign act_ctrl   = ctrl_a[act_ch];
   assign act_to_mem = act_ctrl.to_mem;
   assign act_mode   = act_ctrl.mode;
   assign act_bb     = bb_a[act_ch];
   assign act_addr   = addr_a[act_ch];
   assign act_cnt    = cnt_a[act_ch];

   always_comb begin
      cfg_rdata = '0;
      if (blk_hit && int'(sel_ch) < NUM_CH) begin
         case (off)
            4'd0: cfg_rdata = ctrl_to_byte(ctrl_a[sel_ch[CHW-1:0]]);
            4'd1: cfg_rdata = bb_a[sel_ch[CHW-1:0]];
            4'd2: cfg_rdata = addr_a[sel_ch[CHW-1:0]][7:0];
            4'd3: cfg_rdata = addr_a[sel_ch[CHW-1:0]][15:8];
            4'd4: cfg_rdata = addr_a[sel_ch[CHW-1:0]][23:16];
            4'd5: cfg_rdata = cnt_a[sel_ch[CHW-1:0]][7:0];
            4'd6: cfg_rdata = cnt_a[sel_ch[CHW-1:0]][15:8];
            default: cfg_rdata = '0;
         endcase
      end
   end

   AST_CNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      step && !cfg_we |=> act_cnt == $past(act_cnt) - CW'(1)); // R7

   AST_FIXED_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      step && act_ctrl.fixed && !cfg_we |=> $stable(act_addr)); // R6
endmodule

// File: rtl/dma8_sequencer.sv
module dma8_sequencer
   import dma8_pkg::*;
#(
   parameter int          NUM_CH    = 8,
   parameter int          CHW       = 3,
   parameter logic [23:0] PAGE_BASE = 24'h002100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NUM_CH-1:0] start_mask,
   input  logic              act_to_mem,
   input  logic [2:0]        act_mode,
   input  logic [7:0]        act_bb,
   input  logic [AW-1:0]     act_addr,
   input  logic [CW-1:0]     act_cnt,
   output logic [CHW-1:0]    act_ch,
   output logic              step,
   output logic              bus_req,
   output logic              bus_we,
   output logic [AW-1:0]     bus_addr,
   output logic [DW-1:0]     bus_wdata,
   input  logic [DW-1:0]     bus_rdata,
   input  logic              bus_ready,
   output logic              busy
);
   seq_state_t        state;
   logic [NUM_CH-1:0] pend;
   logic              pat;
   logic [DW-1:0]     dat;
   logic [CHW-1:0]    pick;
   logic [AW-1:0]     baddr;

   function automatic logic [CHW-1:0] lowest(input logic [NUM_CH-1:0] m);
      logic [CHW-1:0] idx;
      idx = '0;
      for (int i = NUM_CH - 1; i >= 0; i--)
         if (m[i]) idx = CHW'(i);
      return idx;
   endfunction

   assign pick  = lowest(pend);
   assign baddr = PAGE_BASE | {15'd0, ({1'b0, act_bb} + {8'd0, pat})};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         pend   <= '0;
         act_ch <= '0;
         pat    <= 1'b0;
         dat    <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start && start_mask != '0) begin
               pend  <= start_mask;
               state <= ST_PICK;
            end
            ST_PICK: if (pend == '0) begin
               state <= ST_IDLE;
            end else begin
               act_ch <= pick;
               pend   <= pend & ~(NUM_CH'(1) << pick);
               pat    <= 1'b0;
               state  <= ST_RD;
            end
            ST_RD: if (bus_ready) begin
               dat   <= bus_rdata;
               state <= ST_WR;
            end
            ST_WR: if (bus_ready) begin
               pat   <= (act_mode == 3'd1) ? ~pat : 1'b0;
               state <= (act_cnt == CW'(1)) ? ST_PICK : ST_RD;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_req   = (state == ST_RD) || (state == ST_WR);
      bus_we    = (state == ST_WR);
      bus_wdata = dat;
      if (state == ST_WR) bus_addr = act_to_mem ? act_addr : baddr;
      else                bus_addr = act_to_mem ? baddr : act_addr;
      step = (state == ST_WR) && bus_ready;
      busy = (state != ST_IDLE);
   end

   AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && start_mask != '0 |=> busy); // R8

   AST_NO_NEW_WORK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (pend & ~$past(pend)) == '0); // R8

   AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_we && bus_ready |=> bus_req && bus_we); // R4
endmodule

// File: rtl/dma8_engine.sv
module dma8_engine
   import dma8_pkg::*;
#(
   parameter int          NUM_CH    = 8,
   parameter int          CFG_AW    = 16,
   parameter logic [15:0] CH_BASE   = 16'h4300,
   parameter logic [15:0] EN_ADDR   = 16'h420B,
   parameter logic [23:0] PAGE_BASE = 24'h002100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [23:0]       bus_addr,
   output logic [7:0]        bus_wdata,
   input  logic [7:0]        bus_rdata,
   input  logic              bus_ready,
   output logic              busy
);
   localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("dma8_engine: NUM_CH must lie in 1..8");
   end
   if (CH_BASE[6:0] != 7'd0) begin : g_bad_base
      $error("dma8_engine: CH_BASE must be aligned to 128");
   end
   if (CFG_AW != 16) begin : g_bad_aw
      $error("dma8_engine: CFG_AW must be 16");
   end

   logic           start;
   logic [CHW-1:0] act_ch;
   logic           step;
   logic           act_to_mem;
   logic [2:0]     act_mode;
   logic [7:0]     act_bb;
   logic [AW-1:0]  act_addr;
   logic [CW-1:0]  act_cnt;

   assign start = cfg_we && (cfg_addr == EN_ADDR);

   dma8_regbank #(
      .NUM_CH (NUM_CH),
      .CFG_AW (CFG_AW),
      .CH_BASE(CH_BASE),
      .CHW    (CHW)
   ) u_regbank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .act_ch    (act_ch),
      .step      (step),
      .act_to_mem(act_to_mem),
      .act_mode  (act_mode),
      .act_bb    (act_bb),
      .act_addr  (act_addr),
      .act_cnt   (act_cnt)
   );

   dma8_sequencer #(
      .NUM_CH   (NUM_CH),
      .CHW      (CHW),
      .PAGE_BASE(PAGE_BASE)
   ) u_sequencer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_mask(cfg_wdata[NUM_CH-1:0]),
      .act_to_mem(act_to_mem),
      .act_mode  (act_mode),
      .act_bb    (act_bb),
      .act_addr  (act_addr),
      .act_cnt   (act_cnt),
      .act_ch    (act_ch),
      .step      (step),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_ready (bus_ready),
      .busy      (busy)
   );

   logic [7:0] last_rd;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              last_rd <= '0;
      else if (bus_req && !bus_we && bus_ready) last_rd <= bus_rdata;
   end

   AST_WRITE_ECHOES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we |-> bus_wdata == last_rd); // R4

   AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ready && !cfg_we |=> bus_req && $stable(bus_addr)
         && $stable(bus_we) && $stable(bus_wdata)); // R9
endmodule

// File: tb/dma8_engine_bench.sv
`timescale 1ns/1ps
module dma8_engine_bench;
   localparam logic [15:0] ENR = 16'h420B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        bus_req, bus_we, busy;
   logic [23:0] bus_addr;
   logic [7:0]  bus_wdata, bus_rdata;
   logic        bus_ready = 1'b1;

   always #2.5 clk = ~clk;

   dma8_engine u_dma8_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy)
   );

   function automatic logic [7:0] mem_val(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'h5A;
   endfunction
   assign bus_rdata = mem_val(bus_addr);

   int n_tests = 0, n_fail = 0;
   bit finished = 0;
   logic [24:0] exp_q[$];
   int mis = 0, extra = 0, hold_err = 0;
   logic [23:0] last_rd = '0;
   logic [24:0] f_act = '0, f_exp = '0;
   bit stall_en = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit prev_stall = 0;
   logic [23:0] prev_addr = '0;
   logic prev_we = 0;

   logic [7:0]  sh_ctrl [8];
   logic [7:0]  sh_bb   [8];
   logic [23:0] sh_a    [8];
   logic [15:0] sh_cnt  [8];

   always @(negedge clk) begin
      if (stall_en) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         bus_ready = lfsr[0] | lfsr[3];
      end else begin
         bus_ready = 1'b1;
      end
      #1;
      if (prev_stall && (!bus_req || bus_addr != prev_addr || bus_we != prev_we))
         hold_err++;
      prev_stall = bus_req && !bus_ready;
      prev_addr  = bus_addr;
      prev_we    = bus_we;
      if (bus_req && bus_ready) begin
         if (exp_q.size() == 0) begin
            extra++;
         end else begin
            logic [24:0] e;
            e = exp_q.pop_front();
            if (e != {bus_we, bus_addr}) begin
               if (mis == 0) begin f_act = {bus_we, bus_addr}; f_exp = e; end
               mis++;
            end
            if (bus_we && bus_wdata != mem_val(last_rd)) mis++;
         end
         if (!bus_we) last_rd = bus_addr;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   function automatic logic [15:0] reg_at(input int ch, input int off);
      return 16'h4300 + 16'(ch * 16) + 16'(off);
   endfunction

   task automatic setup_ch(input int ch, input logic [7:0] ctrl, input logic [7:0] bb,
                           input logic [23:0] a, input logic [15:0] cnt);
      cfg_wr(reg_at(ch, 0), ctrl);
      cfg_wr(reg_at(ch, 1), bb);
      cfg_wr(reg_at(ch, 2), a[7:0]);
      cfg_wr(reg_at(ch, 3), a[15:8]);
      cfg_wr(reg_at(ch, 4), a[23:16]);
      cfg_wr(reg_at(ch, 5), cnt[7:0]);
      cfg_wr(reg_at(ch, 6), cnt[15:8]);
      sh_ctrl[ch] = ctrl; sh_bb[ch] = bb; sh_a[ch] = a; sh_cnt[ch] = cnt;
   endtask

   task automatic build_exp(input logic [7:0] mask);
      logic [23:0] a, b;
      logic off;
      int n;
      for (int c = 0; c < 8; c++) begin
         if (mask[c]) begin
            a = sh_a[c]; off = 1'b0;
            n = (sh_cnt[c] == 16'd0) ? 65536 : int'(sh_cnt[c]);
            for (int i = 0; i < n; i++) begin
               b = 24'h002100 | {15'd0, ({1'b0, sh_bb[c]} + {8'd0, off})};
               if (!sh_ctrl[c][7]) begin
                  exp_q.push_back({1'b0, a}); exp_q.push_back({1'b1, b});
               end else begin
                  exp_q.push_back({1'b0, b}); exp_q.push_back({1'b1, a});
               end
               if (!sh_ctrl[c][3]) a = sh_ctrl[c][4] ? a - 24'd1 : a + 24'd1;
               off = (sh_ctrl[c][2:0] == 3'd1) ? ~off : 1'b0;
            end
            sh_a[c] = a; sh_cnt[c] = '0;
         end
      end
   endtask

   task automatic read_back(input int ch, input string req);
      logic [7:0] b0, b1, b2;
      cfg_rd(reg_at(ch, 2), b0); cfg_rd(reg_at(ch, 3), b1); cfg_rd(reg_at(ch, 4), b2);
      check({b2, b1, b0} == sh_a[ch], req, "final memory address", {b2, b1, b0}, sh_a[ch]);
      cfg_rd(reg_at(ch, 5), b0); cfg_rd(reg_at(ch, 6), b1);
      check({b1, b0} == 16'd0, "R7", "count after transfer", {b1, b0}, 0);
   endtask

   task automatic run(input logic [7:0] mask, input string req);
      mis = 0; extra = 0; hold_err = 0;
      build_exp(mask);
      cfg_wr(ENR, mask);
      check(busy == 1'b1, "R8", "busy after start", busy, 1);
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check(mis == 0 && extra == 0 && exp_q.size() == 0, req,
            "transaction sequence", f_act, f_exp);
      check(hold_err == 0, "R9", "request held while stalled", hold_err, 0);
      exp_q.delete();
      for (int c = 0; c < 8; c++) if (mask[c]) read_back(c, req);
   endtask

   initial begin
      logic [7:0] d0, d1, d2;
      int idx;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && bus_req == 1'b0, "R10", "idle in reset", {busy, bus_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && bus_req == 1'b0, "R10", "idle after reset", {busy, bus_req}, 0);
      cfg_rd(reg_at(3, 2), d0);
      check(d0 == 8'h00, "R10", "reset register value", d0, 0);

      // R1 read-back and R2 byte-isolated address writes
      setup_ch(2, 8'hFF, 8'h34, 24'h123456, 16'hBEEF);
      cfg_rd(reg_at(2, 0), d0);
      check(d0 == 8'hDF, "R1", "control read-back", d0, 8'hDF);
      cfg_rd(reg_at(2, 1), d0);
      check(d0 == 8'h34, "R1", "index read-back", d0, 8'h34);
      cfg_rd(reg_at(2, 5), d0); cfg_rd(reg_at(2, 6), d1);
      check({d1, d0} == 16'hBEEF, "R1", "count read-back", {d1, d0}, 16'hBEEF);
      cfg_wr(reg_at(2, 3), 8'hAB);
      cfg_rd(reg_at(2, 2), d0); cfg_rd(reg_at(2, 3), d1); cfg_rd(reg_at(2, 4), d2);
      check({d2, d1, d0} == 24'h12AB56, "R2", "middle byte write", {d2, d1, d0}, 24'h12AB56);

      // R4 R5 R6 sweep: direction x mode x stepping
      idx = 0;
      for (int dir = 0; dir < 2; dir++)
         for (int m = 0; m < 3; m++)
            for (int st = 0; st < 3; st++) begin
               logic [7:0] ctrl;
               logic [2:0] mode;
               mode = (m == 0) ? 3'd0 : (m == 1) ? 3'd1 : 3'd5;
               ctrl = {dir[0], 2'b00, st == 1, st == 2, mode};
               stall_en = idx[0];
               setup_ch(idx % 8, ctrl, 8'(8'h10 + idx * 7),
                        (idx == 4) ? 24'h000001 : 24'h7F0000 + 24'(idx * 257), 16'd3);
               run(8'(1 << (idx % 8)), dir ? "R4 R5 R6 to-memory" : "R4 R5 R6 to-peripheral");
               idx++;
            end
      stall_en = 0;

      // R5 index carry in alternating mode
      setup_ch(4, 8'h01, 8'hFF, 24'h001000, 16'd4);
      run(8'h10, "R5 index carry");

      // R3 priority order from one start write
      setup_ch(0, 8'h00, 8'h01, 24'h100000, 16'd2);
      setup_ch(1, 8'h00, 8'h02, 24'h110000, 16'd2);
      setup_ch(2, 8'h81, 8'h03, 24'h120000, 16'd2);
      setup_ch(5, 8'h10, 8'h04, 24'h150000, 16'd2);
      setup_ch(7, 8'h08, 8'h05, 24'h170000, 16'd2);
      stall_en = 1;
      run(8'hA5, "R3 channel order");
      stall_en = 0;
      cfg_rd(reg_at(1, 5), d0);
      check(d0 == 8'd2, "R3", "unselected channel untouched", d0, 2);

      // R8 start writes while busy are ignored
      setup_ch(0, 8'h00, 8'h20, 24'h200000, 16'd4);
      setup_ch(1, 8'h00, 8'h21, 24'h210000, 16'd2);
      mis = 0; extra = 0;
      build_exp(8'h01);
      cfg_wr(ENR, 8'h01);
      check(busy == 1'b1, "R8", "busy after start", busy, 1);
      cfg_wr(ENR, 8'h02);
      while (busy) @(negedge clk);
      repeat (10) @(negedge clk);
      check(mis == 0 && extra == 0 && exp_q.size() == 0, "R8",
            "no work from start while busy", extra, 0);
      check(busy == 1'b0, "R8", "busy low after finish", busy, 0);
      cfg_rd(reg_at(1, 5), d0);
      check(d0 == 8'd2, "R8", "ignored channel count kept", d0, 2);
      exp_q.delete();

      // R7 zero count moves 65536 bytes
      setup_ch(6, 8'h00, 8'h18, 24'hFFFF00, 16'd0);
      run(8'h40, "R7 full-size transfer");
      check(sh_a[6] == 24'h00FF00, "R7", "model wrap value", sh_a[6], 24'h00FF00);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule